// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Line Transmitter

This block turns a stream of stereo sample pairs into a single self-clocking serial line in the consumer digital audio interface format, at a fixed 1x rate. Each frame holds a left and a right subframe of 32 slots each. The first four slots of a subframe carry a raw sync pattern. The remaining 28 slots are biphase-mark coded and hold zero padding, the audio word (LSB first), and the validity, user, channel-status and parity flags.

The line is paced by a clock enable, `half_en`, that pulses once per half-slot. A frame therefore takes 128 enable pulses. A new sample pair is taken only on the enable pulse that opens a frame. The block has a ready/valid handshake: if no pair is offered at that point, the transmitter stops and holds the line low. It also clears its block and user counters, so the next frame that is sent starts a fresh 32-frame block and a fresh 98-frame user cycle.

Channel-status bits come from a constant pattern with one bit per frame of the block. User bits follow their own longer cycle.

Top module: `spdif_serializer`

## Requirements
- R1: The line output is registered and changes only in the clock cycle after a cycle in which `half_en` is high. It is stable in every other cycle.
- R2: Slots 0 to 3 of each subframe are sent as raw 8-half-cell patterns, first half-cell first. The patterns are: start-of-block 11101000, other left subframes 11100010, right subframes 11100100.
- R3: In slots 4 to 31 the line toggles at the start of every slot, and toggles again at mid-slot when the slot's bit is 1.
- R4: With the default 16-bit width, slots 4 to 11 carry 0. Slots 12 to 27 carry the subframe's sample, with bit 0 in slot 12 and bit 15 in slot 27.
- R5: Slot 28 (validity) is always 0.
- R6: Slot 29 (user) is 1 only in a left subframe whose frame is at position 2 or later of the 98-frame user cycle. Otherwise it is 0. The user cycle restarts at position 0 after a stop.
- R7: Slot 30 (channel status) of both subframes of block frame k equals bit k of the 32-bit constant pattern. The default pattern is 0x0000000A, so frames 1 and 3 carry 1.
- R8: Slot 31 (parity) makes the number of ones in slots 4 to 31 even, so every subframe ends with the line low.
- R9: `smp_ready` is high exactly on an enable pulse at a frame start. The pair on `smp_left`/`smp_right` is captured only when `smp_valid` and `smp_ready` are both high. Data presented at any other time has no effect on the line.
- R10: An enable pulse at a frame start with `smp_valid` low stops transmission. The line goes and stays low, and the block and user counters return to 0.
- R11: The frame counter wraps every 32 frames. The start-of-block pattern reappears on the left subframe of every 32nd frame of continuous transmission.
- R12: While reset is asserted and directly after it, the line is low and `smp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | Clock enable, one pulse per half-slot |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | Pair accepted this cycle if valid (frame start) |
| smp_left | input | 16 | Left-channel sample |
| smp_right | input | 16 | Right-channel sample |
| line_out | output | 1 | Biphase-mark serial line |

## Verification
`smp_ready` is combinational, so the bench reads it one time step after it raises `half_en`, in the same cycle. Each half-cell of the line is due one clock after the rising edge that sees the enable, so the bench compares it at the next falling edge against a reference model that advances once per enable pulse. During the random idle gaps between pulses, the bench rechecks the same expected level on each falling edge to show that the line holds still.

// File: rtl/spdtx_pkg.sv
package spdtx_pkg;

   // position of the next half-cell to be placed on the line
   typedef struct packed {
      logic       sub;    // 0 = left subframe, 1 = right subframe
      logic [4:0] slot;   // slot within the subframe
      logic       half;   // 0 = first half of the slot
   } cell_pos_t;

   typedef enum logic [1:0] {
      SYNC_BLOCK = 2'd0,
      SYNC_LEFT  = 2'd1,
      SYNC_RIGHT = 2'd2
   } sync_kind_e;

   localparam int SLOTS_PER_SUB = 32;
   localparam int SYNC_SLOTS    = 4;
   localparam int FLAG_V_SLOT   = 28;
   localparam int FLAG_U_SLOT   = 29;
   localparam int FLAG_C_SLOT   = 30;
   localparam int FLAG_P_SLOT   = 31;

   function automatic logic [7:0] sync_pattern(input sync_kind_e k);
      case (k)
         SYNC_BLOCK: sync_pattern = 8'b1110_1000;
         SYNC_LEFT:  sync_pattern = 8'b1110_0010;
         default:    sync_pattern = 8'b1110_0100;
      endcase
   endfunction

endpackage

// File: rtl/spdtx_frame_seq.sv
module spdtx_frame_seq
   import spdtx_pkg::*;
#(
   parameter int BLOCK_FRAMES = 32,
   parameter int USER_PERIOD  = 98,
   localparam int FW = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1,
   localparam int UW = (USER_PERIOD > 1) ? $clog2(USER_PERIOD) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          half_en,
   input  logic          smp_valid,
   output cell_pos_t     pos,
   output logic          boundary,
   output logic          emit,
   output logic          take,
   output logic          stop,
   output logic [FW-1:0] frame_idx,
   output logic [UW-1:0] user_idx,
   output sync_kind_e    sync_sel
);

   cell_pos_t pos_q, pos_n;
   logic      frame_end;

   assign pos       = pos_q;
   assign boundary  = (pos_q == '0);
   assign take      = half_en & boundary & smp_valid;
   assign stop      = half_en & boundary & ~smp_valid;
   assign emit      = half_en & (~boundary | smp_valid);
   assign frame_end = pos_q.sub & (pos_q.slot == 5'd31) & pos_q.half;

   always_comb begin
      pos_n = pos_q;
      if (pos_q.half) begin
         pos_n.half = 1'b0;
         if (pos_q.slot == 5'd31) begin
            pos_n.slot = 5'd0;
            pos_n.sub  = ~pos_q.sub;
         end else begin
            pos_n.slot = pos_q.slot + 5'd1;
         end
      end else begin
         pos_n.half = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos_q <= '0;
      else if (emit) pos_q <= pos_n;
   end

   // block position
   generate
      if (BLOCK_FRAMES > 1) begin : g_block_cnt
         logic [FW-1:0] frm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 frm_q <= '0;
            else if (stop)              frm_q <= '0;
            else if (emit && frame_end) frm_q <= (frm_q == FW'(BLOCK_FRAMES - 1)) ? '0 : frm_q + 1'b1;
         end
         assign frame_idx = frm_q;
      end else begin : g_block_one
         assign frame_idx = '0;
      end
   endgenerate

   // user-data cycle position
   generate
      if (USER_PERIOD > 1) begin : g_user_cnt
         logic [UW-1:0] usr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 usr_q <= '0;
            else if (stop)              usr_q <= '0;
            else if (emit && frame_end) usr_q <= (usr_q == UW'(USER_PERIOD - 1)) ? '0 : usr_q + 1'b1;
         end
         assign user_idx = usr_q;
      end else begin : g_user_one
         assign user_idx = '0;
      end
   endgenerate

   always_comb begin
      if (pos_q.sub)              sync_sel = SYNC_RIGHT;
      else if (frame_idx == '0)   sync_sel = SYNC_BLOCK;
      else                        sync_sel = SYNC_LEFT;
   end

endmodule

// File: rtl/spdtx_slot_mux.sv
module spdtx_slot_mux
   import spdtx_pkg::*;
#(
   parameter int                      SAMPLE_W      = 16,
   parameter int                      BLOCK_FRAMES  = 32,
   parameter int                      USER_PERIOD   = 98,
   parameter int                      USER_ONE_FROM = 2,
   parameter logic [BLOCK_FRAMES-1:0] CS_PATTERN    = 'hA,
   localparam int FW     = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1,
   localparam int UW     = (USER_PERIOD > 1) ? $clog2(USER_PERIOD) : 1,
   localparam int AUD_LO = FLAG_V_SLOT - SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                emit,
   input  logic                take,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  cell_pos_t           pos,
   input  logic [FW-1:0]       frame_idx,
   input  logic [UW-1:0]       user_idx,
   output logic                cell_bit
);

   logic [SAMPLE_W-1:0] left_q, right_q, smp_cur;
   logic [31:0]         slot_vec;
   logic                usr_bit, cs_bit, par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         right_q <= '0;
      end else if (take) begin
         left_q  <= in_left;
         right_q <= in_right;
      end
   end

   assign smp_cur = pos.sub ? right_q : left_q;

   generate
      if (USER_PERIOD > USER_ONE_FROM) begin : g_user_on
         assign usr_bit = ~pos.sub & (user_idx >= UW'(USER_ONE_FROM));
      end else begin : g_user_off
         logic unused_u;
         assign unused_u = ^user_idx;
         assign usr_bit  = 1'b0;
      end
   endgenerate

   assign cs_bit = CS_PATTERN[frame_idx];

   // bit carried by each slot of the current subframe
   generate
      for (genvar s = 0; s < SLOTS_PER_SUB; s++) begin : g_slot
         if (s < AUD_LO) begin : g_zero
            assign slot_vec[s] = 1'b0;
         end else if (s < FLAG_V_SLOT) begin : g_aud
            assign slot_vec[s] = smp_cur[s - AUD_LO];
         end else if (s == FLAG_V_SLOT) begin : g_v
            assign slot_vec[s] = 1'b0;
         end else if (s == FLAG_U_SLOT) begin : g_u
            assign slot_vec[s] = usr_bit;
         end else if (s == FLAG_C_SLOT) begin : g_c
            assign slot_vec[s] = cs_bit;
         end else begin : g_p
            assign slot_vec[s] = par_q;
         end
      end
   endgenerate

   assign cell_bit = slot_vec[pos.slot];

   // running parity over the coded slots before the parity slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
      end else if (emit) begin
         if (pos.slot < 5'(SYNC_SLOTS))
            par_q <= 1'b0;
         else if (pos.half && (pos.slot != 5'(FLAG_P_SLOT)))
            par_q <= par_q ^ cell_bit;
      end
   end

endmodule

// File: rtl/spdtx_bmc_enc.sv
module spdtx_bmc_enc
   import spdtx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       emit,
   input  logic       stop,
   input  cell_pos_t  pos,
   input  sync_kind_e sync_sel,
   input  logic       cell_bit,
   output logic       line
);

   logic       line_q;
   logic [7:0] pat;
   logic [2:0] pidx;

   assign pat  = sync_pattern(sync_sel);
   assign pidx = 3'd7 - {pos.slot[1:0], pos.half};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
      end else if (stop) begin
         line_q <= 1'b0;
      end else if (emit) begin
         if (pos.slot < 5'(SYNC_SLOTS))
            line_q <= pat[pidx];
         else if (!pos.half)
            line_q <= ~line_q;
         else if (cell_bit)
            line_q <= ~line_q;
      end
   end

   assign line = line_q;

endmodule

// File: rtl/spdif_serializer.sv
module spdif_serializer
   import spdtx_pkg::*;
#(
   parameter int                      SAMPLE_W      = 16,
   parameter int                      BLOCK_FRAMES  = 32,
   parameter int                      USER_PERIOD   = 98,
   parameter int                      USER_ONE_FROM = 2,
   parameter logic [BLOCK_FRAMES-1:0] CS_PATTERN    = 'hA,
   localparam int FW = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1,
   localparam int UW = (USER_PERIOD > 1) ? $clog2(USER_PERIOD) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                half_en,
   input  logic                smp_valid,
   output logic                smp_ready,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   output logic                line_out
);

   generate
      if (SAMPLE_W < 16 || SAMPLE_W > 24) begin : g_bad_width
         $error("SAMPLE_W must lie in 16..24");
      end
      if (BLOCK_FRAMES < 1 || BLOCK_FRAMES > 256) begin : g_bad_block
         $error("BLOCK_FRAMES must lie in 1..256");
      end
      if (USER_PERIOD < 1) begin : g_bad_user
         $error("USER_PERIOD must be at least 1");
      end
   endgenerate

   cell_pos_t     cpos;
   logic          boundary, emit, take, stop, cell_bit;
   logic [FW-1:0] frame_idx;
   logic [UW-1:0] user_idx;
   sync_kind_e    sync_sel;

   spdtx_frame_seq #(
      .BLOCK_FRAMES (BLOCK_FRAMES),
      .USER_PERIOD  (USER_PERIOD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_en   (half_en),
      .smp_valid (smp_valid),
      .pos       (cpos),
      .boundary  (boundary),
      .emit      (emit),
      .take      (take),
      .stop      (stop),
      .frame_idx (frame_idx),
      .user_idx  (user_idx),
      .sync_sel  (sync_sel)
   );

   spdtx_slot_mux #(
      .SAMPLE_W      (SAMPLE_W),
      .BLOCK_FRAMES  (BLOCK_FRAMES),
      .USER_PERIOD   (USER_PERIOD),
      .USER_ONE_FROM (USER_ONE_FROM),
      .CS_PATTERN    (CS_PATTERN)
   ) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .emit      (emit),
      .take      (take),
      .in_left   (smp_left),
      .in_right  (smp_right),
      .pos       (cpos),
      .frame_idx (frame_idx),
      .user_idx  (user_idx),
      .cell_bit  (cell_bit)
   );

   spdtx_bmc_enc u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .emit     (emit),
      .stop     (stop),
      .pos      (cpos),
      .sync_sel (sync_sel),
      .cell_bit (cell_bit),
      .line     (line_out)
   );

   assign smp_ready = half_en & boundary;

endmodule

// File: rtl/spdtx_chk.sv
module spdtx_chk
   import spdtx_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      half_en,
   input logic      smp_valid,
   input logic      smp_ready,
   input logic      line_out,
   input cell_pos_t cpos
);

   AST_LINE_HOLDS_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !half_en |=> $stable(line_out)); // R1

   AST_SYNC_LEADS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (half_en && cpos.slot == 5'd0 && !cpos.half && (cpos.sub || smp_valid)) |=> line_out); // R2

   AST_SLOT_EDGE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (half_en && cpos.slot >= 5'd4 && !cpos.half) |=> (line_out != $past(line_out))); // R3

   AST_SUBFRAME_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (half_en && cpos.slot == 5'd31 && cpos.half) |=> !line_out); // R8

   AST_READY_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ready |-> half_en); // R9

   AST_STOP_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_ready && !smp_valid) |=> !line_out); // R10

endmodule

bind spdif_serializer spdtx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .half_en   (half_en),
   .smp_valid (smp_valid),
   .smp_ready (smp_ready),
   .line_out  (line_out),
   .cpos      (cpos)
);

// File: tb/spdif_serializer_tb.sv
module spdif_serializer_tb;

   localparam logic [31:0] CS_TABLE = 32'h0000_000A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        half_en = 1'b0;
   logic        smp_valid = 1'b0;
   logic        smp_ready;
   logic [15:0] smp_left = '0;
   logic [15:0] smp_right = '0;
   logic        line_out;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   spdif_serializer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_en   (half_en),
      .smp_valid (smp_valid),
      .smp_ready (smp_ready),
      .smp_left  (smp_left),
      .smp_right (smp_right),
      .line_out  (line_out)
   );

   // reference model state
   int          m_slot = 0, m_half = 0, m_sub = 0, m_frame = 0, m_ucnt = 0;
   logic        m_lvl = 1'b0;
   logic [15:0] m_l = '0, m_r = '0;
   logic [15:0] dir_smp [4] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h5555};
   int          dir_i = 0;

   task automatic check(input logic act, input logic exp, input string req);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b (slot %0d half %0d sub %0d frame %0d)",
                  req, act, exp, m_slot, m_half, m_sub, m_frame);
      end
   endtask

   function automatic logic slot_bit(input int slot);
      logic [15:0] s;
      logic        u, c;
      s = (m_sub != 0) ? m_r : m_l;
      u = (m_sub == 0) && (m_ucnt >= 2);
      c = CS_TABLE[m_frame];
      if (slot < 12)       return 1'b0;
      else if (slot < 28)  return s[slot - 12];
      else if (slot == 28) return 1'b0;
      else if (slot == 29) return u;
      else if (slot == 30) return c;
      else                 return ^{s, u, c};
   endfunction

   // one enable pulse: returns the expected line level and the requirement it checks
   task automatic model_step(input logic v, input logic [15:0] l, input logic [15:0] r,
                             output logic exp, output string req);
      logic [7:0] pat;
      logic       b;
      if (m_slot == 0 && m_half == 0 && m_sub == 0) begin
         if (!v) begin
            m_frame = 0; m_ucnt = 0; m_lvl = 1'b0;
            exp = 1'b0; req = "R10";
            return;
         end
         m_l = l; m_r = r;
      end
      if (m_slot < 4) begin
         pat = (m_sub != 0) ? 8'b1110_0100 : (m_frame == 0) ? 8'b1110_1000 : 8'b1110_0010;
         exp = pat[7 - (m_slot * 2 + m_half)];
         req = (m_sub == 0 && m_frame == 0) ? "R11" : "R2";
      end else begin
         b = slot_bit(m_slot);
         exp = (m_half == 0) ? ~m_lvl : (b ? ~m_lvl : m_lvl);
         if (m_half == 0)       req = "R3";
         else if (m_slot == 28) req = "R5";
         else if (m_slot == 29) req = "R6";
         else if (m_slot == 30) req = "R7";
         else if (m_slot == 31) req = "R8";
         else                   req = "R4";
      end
      m_lvl = exp;
      if (m_half == 1) begin
         if (m_slot == 31) begin
            m_slot = 0;
            if (m_sub == 1) begin
               m_frame = (m_frame + 1) % 32;
               m_ucnt  = (m_ucnt + 1) % 98;
            end
            m_sub = 1 - m_sub;
         end else begin
            m_slot++;
         end
         m_half = 0;
      end else begin
         m_half = 1;
      end
   endtask

   // drive one enable pulse from a falling edge, then idle for gap cycles
   task automatic tick(input logic v, input int gap);
      logic        bnd, exp;
      logic [15:0] l, r;
      string       req;
      bnd = (m_slot == 0 && m_half == 0 && m_sub == 0);
      l = 16'($urandom);
      r = 16'($urandom);
      if (bnd && v && dir_i < 4) begin
         l = dir_smp[dir_i];
         r = ~dir_smp[dir_i];
         dir_i++;
      end
      smp_left = l; smp_right = r; smp_valid = v; half_en = 1'b1;
      #1;
      check(smp_ready, bnd, "R9");
      model_step(v, l, r, exp, req);
      @(posedge clk); @(negedge clk);
      half_en = 1'b0;
      smp_left = 16'($urandom); smp_right = 16'($urandom);   // ignored off the frame start (R9)
      check(line_out, exp, req);
      if (m_slot == 0 && m_half == 0 && req == "R8") check(line_out, 1'b0, "R8");
      for (int g = 0; g < gap; g++) begin
         @(posedge clk); @(negedge clk);
         check(line_out, exp, "R1");
      end
   endtask

   task automatic run_frames(input int n);
      for (int f = 0; f < n; f++)
         for (int t = 0; t < 128; t++)
            tick(1'b1, int'($urandom % 3));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(line_out, 1'b0, "R12");
      check(smp_ready, 1'b0, "R12");
      rst_n = 1'b1;
      @(negedge clk);
      check(line_out, 1'b0, "R12");
      // stopped: nothing offered
      for (int i = 0; i < 3; i++) tick(1'b0, 1);
      // continuous run over a full user cycle and several blocks
      run_frames(100);
      // underflow stops the line, counters restart
      for (int i = 0; i < 3; i++) tick(1'b0, 2);
      run_frames(40);
      for (int i = 0; i < 2; i++) tick(1'b0, 0);
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #(4 * 190000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule